// File: doc/BRIEF.md
# Dual-Rate Third-Order Sinc Decimator

This block turns the single-bit output of a second-order delta-sigma modulator into signed 16-bit words. The input carries one modulator sample per clock. Ones and zeros are taken as +1 and −1, and their local density encodes the signal. The filter is a third-order cascaded integrator-comb (CIC) structure. Three wrapping integrators run on every modulator sample. Three differencing stages run once per output period. The overall response is the cube of an N-tap moving sum, scaled so that full scale maps onto the 16-bit range.

A rate-select input sets the decimation factor at run time. When it is high the factor is 128, which gives the faster word rate. When it is low the factor is 256, which gives half that rate. The filter needs three whole output periods to fill after it starts. So after reset, after a restart pulse, and after any change of the rate input, the first two words are withheld. The third word is the first one marked valid.

Top module: `sinc3_decimator`

## Requirements
- R1: A bit value of 1 counts as +1 and a value of 0 counts as −1. Take a stream whose pattern period divides N and whose density of ones is p. Every valid word for that stream equals (2p−1)·32768, limited to the range −32768..32767.
- R2: The output is the input passed through three cascaded N-sample moving sums, scaled down by a shift of 3·log2(N)−15. The unscaled result never exceeds N³ in magnitude.
- R3: `word_valid` is high for one clock per emitted word. `word_out` changes only in a cycle where `word_valid` is high, and it holds its value otherwise.
- R4: With `rate_fast`=1 the decimation factor N is 128; with `rate_fast`=0 it is 256. Count samples from 0 after a clear. Valid words then appear after samples 3N−1, 4N−1, 5N−1, and so on. Each valid word is visible in the cycle after the sample that completes it.
- R5: No valid word appears until three full output periods have elapsed since the last clear. The words for the first and second periods are dropped.
- R6: When `restart` is high for a cycle, the sample of that cycle is discarded and all filter state is cleared, including the phase and the settle count. A restart during settling therefore starts the three-period wait again.
- R7: A change of `rate_fast` between two clocks clears the filter exactly as a restart does, and the new factor applies from the next sample.
- R8: A full-scale input saturates. A stream of all ones gives 32767 and a stream of all zeros gives −32768, at both rates.
- R9: The accumulators are 3·log2(256)+2 = 26 bits wide and wrap in two's complement. Words stay exact over runs long enough for the integrators to overflow many times.
- R10: While `rst_n` is low, and after it is released, `word_valid` reads 0 and `word_out` reads 0 until the first valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one input sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | One-cycle clear of all filter state |
| rate_fast | input | 1 | 1: decimate by 128; 0: decimate by 256 |
| bit_in | input | 1 | Modulator bit stream |
| word_out | output | 16 | Filtered signed word, held between strobes |
| word_valid | output | 1 | One-cycle strobe marking a settled word |

## Verification
The assertions assume three things. The rate input changes only on clock boundaries. A restart is a level that is sampled once per clock. The bit input is always 0 or 1, so the bound of N³ on the unscaled comb result depends only on the sums being full. The stimulus drives every input on the falling edge. It changes the rate only in cycles that begin a new segment, and it feeds periodic patterns whose period divides both factors. With such patterns each settled word can be predicted from the density of ones alone, whatever the alignment of the pattern. Restarts are placed both after settling and in the middle of settling, and rate changes are made in both directions.

// File: rtl/sinc3_pkg.sv
// Shared definitions for the dual-rate sinc3 decimator.
// Assumes the filter order is fixed at three throughout the block.
package sinc3_pkg;
    localparam int unsigned FILT_ORDER = 3;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    // Accumulator width needed for wrap-safe CIC arithmetic at factor n.
    function automatic int unsigned cic_width(input int unsigned n);
        return FILT_ORDER * $clog2(n) + 2;
    endfunction

    // Right shift that maps n^order onto 2^(out_w-1).
    function automatic int unsigned cic_shift(input int unsigned n, input int unsigned out_w);
        return FILT_ORDER * $clog2(n) - (out_w - 1);
    endfunction
endpackage

// File: rtl/sinc3_phase_ctrl.sv
// Phase and settle control for the decimator.
// It detects a restart or a rate change, which clears the filter. It counts
// samples within each output period and raises tick on the last one. It raises
// emit only on ticks that come after the filter has filled.
// Assumes rate_fast is sampled once per clock like any other input.
module sinc3_phase_ctrl #(
    parameter int unsigned DEC_FAST     = 128,
    parameter int unsigned DEC_SLOW     = 256,
    parameter int unsigned SETTLE_WORDS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic rate_fast,
    output logic clr,
    output logic tick,
    output logic emit
);
    localparam int unsigned CNT_W = $clog2(DEC_SLOW);
    localparam int unsigned SET_W = $clog2(SETTLE_WORDS);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(DEC_FAST - 1);
    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(DEC_SLOW - 1);
    localparam logic [SET_W-1:0] SET_DONE  = SET_W'(SETTLE_WORDS - 1);

    logic             rate_q;
    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] last;
    logic [SET_W-1:0] settle;

    // Remember the rate of the previous cycle so that a change can be detected.
    always_ff @(posedge clk) begin
        rate_q <= rate_fast;
    end

    assign clr  = restart | (rate_fast != rate_q);
    assign last = (rate_fast == sinc3_pkg::RATE_FAST) ? LAST_FAST : LAST_SLOW;
    assign tick = !clr && (phase == last);
    assign emit = tick && (settle == SET_DONE);

    // Count the sample position within the current output period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) phase <= '0;
        else                       phase <= phase + 1'b1;
    end

    // Count elapsed output periods since the last clear, saturating when settled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                  settle <= '0;
        else if (tick && settle != SET_DONE) settle <= settle + 1'b1;
    end

    a_r6_clear_restarts_phase: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (phase == '0) && (settle == '0));

    a_r4_phase_within_period: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (phase <= last));
endmodule

// File: rtl/sinc3_integrators.sv
// Integrator chain of the CIC filter. It maps each input bit to +1 or -1
// and feeds it through ORDER wrapping accumulators. It exports the value the
// last stage will take after the current sample, so the combs see that
// sample without an extra cycle of latency.
// Assumes ORDER >= 2 and that wraparound is harmless because the combs
// difference the results in the same modulus.
module sinc3_integrators #(
    parameter int unsigned ACC_W = 26,
    parameter int unsigned ORDER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_in,
    output logic [ACC_W-1:0] acc_next
);
    logic [ACC_W-1:0] x_val;

    assign x_val = bit_in ? ACC_W'(1) : '1;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        logic [ACC_W-1:0] q;
        logic [ACC_W-1:0] addend;
        if (g == 0) begin : g_first
            assign addend = x_val;
        end else begin : g_next
            assign addend = g_stage[g-1].q;
        end

        // Accumulate the previous stage (or the mapped input) every sample.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) q <= '0;
            else               q <= q + addend;
        end

        a_r6_integrator_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (q == '0));
    end

    assign acc_next = g_stage[ORDER-1].q + g_stage[ORDER-2].q;
endmodule

// File: rtl/sinc3_combs.sv
// Comb chain and output stage of the CIC filter. On each tick it differences
// the integrator value against the one from the previous tick, ORDER times.
// It then shifts the result by the amount for the current rate, saturates it
// to OUT_W bits and, when emit is set, registers it with a one-cycle strobe.
// Assumes tick never coincides with clr, and that BOUND is the largest
// decimation factor raised to the power ORDER.
module sinc3_combs #(
    parameter int unsigned ACC_W    = 26,
    parameter int unsigned ORDER    = 3,
    parameter int unsigned OUT_W    = 16,
    parameter int unsigned SH_FAST  = 6,
    parameter int unsigned SH_SLOW  = 9,
    parameter int unsigned BOUND    = 16777216
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             emit,
    input  logic             rate_fast,
    input  logic [ACC_W-1:0] acc_in,
    output logic [OUT_W-1:0] word_out,
    output logic             word_valid
);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(2 ** (OUT_W - 1));
    localparam logic signed [ACC_W-1:0] B_POS  = ACC_W'(BOUND);

    logic signed [ACC_W-1:0] shifted;
    logic        [OUT_W-1:0] clipped;
    logic        [ACC_W-1:0] full;

    for (genvar g = 0; g < ORDER; g++) begin : g_comb
        logic [ACC_W-1:0] dly;
        logic [ACC_W-1:0] src;
        logic [ACC_W-1:0] diff;
        if (g == 0) begin : g_first
            assign src = acc_in;
        end else begin : g_next
            assign src = g_comb[g-1].diff;
        end
        assign diff = src - dly;

        // Keep this stage's input from the previous output period.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) dly <= '0;
            else if (tick)     dly <= src;
        end
    end

    assign full    = g_comb[ORDER-1].diff;
    assign shifted = $signed(full) >>> (rate_fast ? SH_FAST : SH_SLOW);

    // Limit the scaled result to the output word range.
    always_comb begin
        if (shifted > SAT_HI)      clipped = SAT_HI[OUT_W-1:0];
        else if (shifted < SAT_LO) clipped = SAT_LO[OUT_W-1:0];
        else                       clipped = shifted[OUT_W-1:0];
    end

    // Register a settled word together with its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= emit;
            if (emit) word_out <= clipped;
        end
    end

    a_r2_settled_sum_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> ($signed(full) <= B_POS) && ($signed(full) >= -B_POS));

    a_r3_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_out));

    a_r7_clear_blanks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !word_valid);
endmodule

// File: rtl/sinc3_decimator.sv
// Dual-rate third-order sinc decimator. It converts a delta-sigma bit stream
// into signed OUT_W-bit words, decimating by DEC_FAST or DEC_SLOW as
// rate_fast selects. It withholds words until SETTLE_WORDS output periods
// have passed since the last reset, restart or rate change.
// Assumes DEC_SLOW = 2*DEC_FAST and both are powers of two.
module sinc3_decimator #(
    parameter int unsigned DEC_FAST     = 128,
    parameter int unsigned DEC_SLOW     = 256,
    parameter int unsigned OUT_W        = 16,
    parameter int unsigned SETTLE_WORDS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             rate_fast,
    input  logic             bit_in,
    output logic [OUT_W-1:0] word_out,
    output logic             word_valid
);
    localparam int unsigned ORDER   = sinc3_pkg::FILT_ORDER;
    localparam int unsigned ACC_W   = sinc3_pkg::cic_width(DEC_SLOW);
    localparam int unsigned SH_FAST = sinc3_pkg::cic_shift(DEC_FAST, OUT_W);
    localparam int unsigned SH_SLOW = sinc3_pkg::cic_shift(DEC_SLOW, OUT_W);
    localparam int unsigned BOUND   = DEC_SLOW ** ORDER;

    logic             clr;
    logic             tick;
    logic             emit;
    logic [ACC_W-1:0] acc_next;

    sinc3_phase_ctrl #(
        .DEC_FAST     (DEC_FAST),
        .DEC_SLOW     (DEC_SLOW),
        .SETTLE_WORDS (SETTLE_WORDS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .rate_fast (rate_fast),
        .clr       (clr),
        .tick      (tick),
        .emit      (emit)
    );

    sinc3_integrators #(
        .ACC_W (ACC_W),
        .ORDER (ORDER)
    ) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .bit_in   (bit_in),
        .acc_next (acc_next)
    );

    sinc3_combs #(
        .ACC_W   (ACC_W),
        .ORDER   (ORDER),
        .OUT_W   (OUT_W),
        .SH_FAST (SH_FAST),
        .SH_SLOW (SH_SLOW),
        .BOUND   (BOUND)
    ) u_combs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .tick       (tick),
        .emit       (emit),
        .rate_fast  (rate_fast),
        .acc_in     (acc_next),
        .word_out   (word_out),
        .word_valid (word_valid)
    );
endmodule

// File: tb/test_sinc3_decimator.sv
// Scoreboard bench: the driver queues the expected words and sample indices,
// and a monitor compares them against the strobed outputs.
module test_sinc3_decimator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        rate_fast = 1'b0;
    logic        bit_in = 1'b0;
    logic [15:0] word_out;
    logic        word_valid;

    int checks = 0;
    int errors = 0;
    int cur_idx = -1;
    int exp_val[$];
    int exp_idx[$];
    string exp_req[$];
    bit done = 1'b0;

    always #2 clk = ~clk;

    sinc3_decimator i_sinc3_decimator (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .rate_fast  (rate_fast),
        .bit_in     (bit_in),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Run one segment: clear by restart or rate change, then feed the pattern.
    task automatic run_seg(input bit fast, input int plen, input logic [7:0] pat,
                           input int periods, input bit by_restart, input string req);
        int n;
        int ones;
        int ev;
        n = fast ? 128 : 256;
        ones = 0;
        for (int b = 0; b < plen; b++) ones += int'(pat[b]);
        ev = (2 * ones * 32768) / plen - 32768;
        if (ev > 32767) ev = 32767;
        for (int k = 3; k <= periods; k++) begin
            exp_val.push_back(ev);
            exp_idx.push_back(k * n - 1);
            exp_req.push_back(req);
        end
        @(negedge clk);
        if (by_restart) restart = 1'b1;
        rate_fast = fast;
        bit_in = 1'b1;
        cur_idx = -1;
        @(negedge clk);
        restart = 1'b0;
        for (int s = 0; s < periods * n; s++) begin
            bit_in = pat[s % plen];
            cur_idx = s;
            @(negedge clk);
        end
    endtask

    // Monitor: compare each strobe with the queue, and watch that the word holds between strobes.
    initial begin
        logic [15:0] held;
        held = 16'h0;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && !done) begin
                if (word_valid) begin
                    if (exp_val.size() == 0) begin
                        check(1'b0, "R5", "unexpected word at sample", cur_idx, -1);
                    end else begin
                        int v;
                        int ix;
                        string rq;
                        v = exp_val.pop_front();
                        ix = exp_idx.pop_front();
                        rq = exp_req.pop_front();
                        check($signed(word_out) == v, rq, "word value", $signed(word_out), v);
                        check(cur_idx == ix, "R4", "word sample index", cur_idx, ix);
                    end
                    held = word_out;
                end else if (word_out != held) begin
                    check(1'b0, "R3", "word changed without strobe", $signed(word_out), $signed(held));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish actual %0d expected %0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(word_valid == 1'b0, "R10", "valid in reset", int'(word_valid), 0);
        check(word_out == 16'h0, "R10", "word in reset", int'(word_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(word_valid == 1'b0, "R10", "valid after reset", int'(word_valid), 0);
        check(word_out == 16'h0, "R10", "word after reset", int'(word_out), 0);

        // R8: saturation at full scale, slow rate.
        run_seg(1'b0, 1, 8'b1, 5, 1'b1, "R8");
        run_seg(1'b0, 1, 8'b0, 4, 1'b1, "R8");
        // R7 and R1: rate change to fast with density 3/4 (bits 1,1,1,0).
        run_seg(1'b1, 4, 8'b0111, 6, 1'b0, "R7");
        // R1: density 1/2 gives zero.
        run_seg(1'b1, 2, 8'b01, 5, 1'b1, "R1");
        // R8: full scale at the fast rate.
        run_seg(1'b1, 1, 8'b1, 4, 1'b1, "R8");
        // R6: a restart during settling yields no word, then the wait starts again.
        run_seg(1'b1, 2, 8'b01, 2, 1'b1, "R6");
        run_seg(1'b1, 4, 8'b0001, 5, 1'b1, "R6");
        // R7: rate change back to slow, density 5/8 (bits 1,1,1,1,1,0,0,0).
        run_seg(1'b0, 8, 8'b0001_1111, 5, 1'b0, "R7");
        // R9: long run across many integrator wraps, density 3/4 (bits 1,0,1,1).
        run_seg(1'b0, 4, 8'b1101, 45, 1'b1, "R9");
        // R5: quiet after the last segment, then confirm every expected word arrived.
        restart = 1'b1;
        repeat (300) @(negedge clk);
        check(exp_val.size() == 0, "R5", "words still pending", exp_val.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule